// File: doc/BRIEF.md
# Exception entry state capture unit

This unit computes and holds the machine-state save registers a processor core loads when it takes either a data translation error exception or a debug exception. The core presents a one-cycle take strobe together with the cause flags. It also supplies three effective addresses: the current instruction, the next instruction and the data access. The fourth input is the live machine state register (MSR). On the clock edge that samples the strobe, the unit loads new values into the SRR0, SRR1, MSR, DSISR, DAR and BAR images and forms the vector address to branch to. Registers that the selected cause does not touch keep their previous contents.

Several causes may be raised at once, and a fixed priority resolves them. A data translation error outranks every debug cause. Among the debug causes, the order is development port request first, then instruction breakpoint, then load/store-bus breakpoint, then peripheral breakpoint. The unit also covers one special case: a development port request that is held through reset and taken on the first clock edge after reset. In that case the SRR0 and SRR1 contents are unspecified, so the unit leaves them unchanged and raises a flag.

Bit numbering in this document is big-endian: bit 0 is the MSB of a 32-bit word, so big-endian bit k is vector index 31-k.

Top module: `exc_state_capture`

## Requirements
- R1: When take_i is low, or take_i is high with no cause flag set, every output register keeps its value.
- R2: Cause priority, highest first: data translation error, development port, instruction breakpoint, load/store-bus breakpoint, peripheral breakpoint. Only the winning cause's rules apply.
- R3: On a data translation error, DSISR is rewritten as follows: bit 1 = translation miss, bit 4 = protection violation, bit 6 = store (0 for a load), and all other bits are 0.
- R4: On a data translation error, DAR takes data_ea_i and SRR0 takes cur_ea_i. BAR is unchanged.
- R5: The vector is the base plus an offset. The base is 0xFFF00000 when MSR bit 25 (IP) is 1, and 0 otherwise. The offset is 0x1400 for a translation error, 0x1C00 for a load/store-bus breakpoint, 0x1D00 for an instruction breakpoint, 0x1E00 for a peripheral breakpoint and 0x1F00 for a development port request.
- R6: On a debug exception, SRR0 is set by cause. An instruction breakpoint loads cur_ea_i. A load/store-bus breakpoint, a peripheral breakpoint or a development port request loads next_ea_i.
- R7: On any taken exception, SRR1 bits 0 to 15 are 0 and SRR1 bits 16 to 31 equal MSR bits 16 to 31.
- R8: On any taken exception, the new MSR keeps bit 25 (IP) and bit 19 (ME). Its bit 31 (LE) takes the old bit 15 (ILE), and all other bits are 0.
- R9: A load/store-bus breakpoint loads BAR with data_ea_i. No debug cause changes DSISR or DAR, and only the load/store-bus breakpoint changes BAR.
- R10: A development port request taken on the first clock edge after reset leaves SRR0 and SRR1 unchanged and sets srr_unspec_o. Any other taken exception clears srr_unspec_o.
- R11: During reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| take_i | input | 1 | One-cycle exception take strobe |
| dtlb_err_i | input | 1 | Data translation error cause |
| tlb_miss_i | input | 1 | No translation found |
| prot_viol_i | input | 1 | Protection check denied the access |
| is_store_i | input | 1 | Faulting access is a store |
| ibrk_i | input | 1 | Instruction breakpoint cause |
| lbrk_i | input | 1 | Load/store-bus breakpoint cause |
| pbrk_i | input | 1 | Peripheral breakpoint cause |
| devp_i | input | 1 | Development port request cause |
| cur_ea_i | input | 32 | Effective address of the current instruction |
| next_ea_i | input | 32 | Effective address of the next instruction |
| data_ea_i | input | 32 | Effective address of the data access |
| msr_i | input | 32 | Current machine state register |
| srr0_o | output | 32 | Saved program counter |
| srr1_o | output | 32 | Saved machine state |
| msr_o | output | 32 | New machine state |
| dsisr_o | output | 32 | Data fault status |
| dar_o | output | 32 | Data fault address |
| bar_o | output | 32 | Breakpoint data address |
| vector_o | output | 32 | Exception vector address |
| srr_unspec_o | output | 1 | SRR0/SRR1 unspecified after a reset-time port request |

## Verification
Two functions can meet in one take cycle: the translation-error register update and one or more debug causes. This happens when several cause flags are raised under a single strobe. The random stimulus raises cause flags independently, so such overlaps are frequent, and directed cases raise all five flags together. The expected result is judged against a bench model of the priority. In that model, DSISR, DAR, SRR0 and the vector follow only the winner, and BAR stays untouched unless the load/store-bus breakpoint wins outright.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int unsigned XLEN = 32;

  // big-endian bit numbers of the MSR fields used
  localparam int unsigned MSR_ILE_BE = 15;
  localparam int unsigned MSR_ME_BE  = 19;
  localparam int unsigned MSR_IP_BE  = 25;
  localparam int unsigned MSR_LE_BE  = 31;

  // big-endian bit numbers of DSISR fields
  localparam int unsigned DSI_MISS_BE  = 1;
  localparam int unsigned DSI_PROT_BE  = 4;
  localparam int unsigned DSI_STORE_BE = 6;

  localparam int unsigned NCAUSE = 5;

  typedef enum logic [2:0] {
    CAUSE_NONE = 3'd0,
    CAUSE_DTLB = 3'd1,
    CAUSE_DEVP = 3'd2,
    CAUSE_IBRK = 3'd3,
    CAUSE_LBRK = 3'd4,
    CAUSE_PBRK = 3'd5
  } exc_cause_e;

  function automatic int unsigned be_idx(input int unsigned be);
    return XLEN - 1 - be;
  endfunction

  function automatic logic [XLEN-1:0] vec_offset(input exc_cause_e c);
    case (c)
      CAUSE_DTLB: return 32'h0000_1400;
      CAUSE_LBRK: return 32'h0000_1C00;
      CAUSE_IBRK: return 32'h0000_1D00;
      CAUSE_PBRK: return 32'h0000_1E00;
      CAUSE_DEVP: return 32'h0000_1F00;
      default:    return '0;
    endcase
  endfunction
endpackage

// File: rtl/exc_cause_arb.sv
module exc_cause_arb
  import exc_pkg::*;
(
  input  logic [NCAUSE-1:0] req_i,   // index 0 = highest priority
  output exc_cause_e        cause_o
);
  always_comb begin
    cause_o = CAUSE_NONE;
    for (int i = NCAUSE - 1; i >= 0; i--) begin
      if (req_i[i]) cause_o = exc_cause_e'(3'(i + 1));
    end
  end
endmodule

// File: rtl/exc_next_calc.sv
module exc_next_calc
  import exc_pkg::*;
#(
  parameter logic [XLEN-1:0] HI_BASE = 32'hFFF0_0000,
  parameter logic [XLEN-1:0] LO_BASE = 32'h0000_0000
) (
  input  exc_cause_e      cause_i,
  input  logic            miss_i,
  input  logic            prot_i,
  input  logic            store_i,
  input  logic [XLEN-1:0] cur_ea_i,
  input  logic [XLEN-1:0] next_ea_i,
  input  logic [XLEN-1:0] msr_i,
  output logic [XLEN-1:0] srr0_o,
  output logic [XLEN-1:0] srr1_o,
  output logic [XLEN-1:0] msr_o,
  output logic [XLEN-1:0] dsisr_o,
  output logic [XLEN-1:0] vector_o,
  output logic            any_o,
  output logic            wr_dsi_o,
  output logic            wr_bar_o
);
  localparam int unsigned HALF = XLEN / 2;
  localparam logic [XLEN-1:0] SAVE_MASK = {{HALF{1'b0}}, {HALF{1'b1}}};

  assign any_o    = (cause_i != CAUSE_NONE);
  assign wr_dsi_o = (cause_i == CAUSE_DTLB);
  assign wr_bar_o = (cause_i == CAUSE_LBRK);
  assign srr1_o   = msr_i & SAVE_MASK;
  assign vector_o = (msr_i[be_idx(MSR_IP_BE)] ? HI_BASE : LO_BASE) | vec_offset(cause_i);

  always_comb begin
    msr_o = '0;
    msr_o[be_idx(MSR_IP_BE)] = msr_i[be_idx(MSR_IP_BE)];
    msr_o[be_idx(MSR_ME_BE)] = msr_i[be_idx(MSR_ME_BE)];
    msr_o[be_idx(MSR_LE_BE)] = msr_i[be_idx(MSR_ILE_BE)];
  end

  always_comb begin
    dsisr_o = '0;
    dsisr_o[be_idx(DSI_MISS_BE)]  = miss_i;
    dsisr_o[be_idx(DSI_PROT_BE)]  = prot_i;
    dsisr_o[be_idx(DSI_STORE_BE)] = store_i;
  end

  // breaking instruction for translation error and instruction breakpoint
  always_comb begin
    case (cause_i)
      CAUSE_DTLB, CAUSE_IBRK: srr0_o = cur_ea_i;
      default:                srr0_o = next_ea_i;
    endcase
  end
endmodule

// File: rtl/exc_state_capture.sv
module exc_state_capture
  import exc_pkg::*;
#(
  parameter logic [31:0] HI_BASE = 32'hFFF0_0000,
  parameter logic [31:0] LO_BASE = 32'h0000_0000
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        take_i,
  input  logic        dtlb_err_i,
  input  logic        tlb_miss_i,
  input  logic        prot_viol_i,
  input  logic        is_store_i,
  input  logic        ibrk_i,
  input  logic        lbrk_i,
  input  logic        pbrk_i,
  input  logic        devp_i,
  input  logic [31:0] cur_ea_i,
  input  logic [31:0] next_ea_i,
  input  logic [31:0] data_ea_i,
  input  logic [31:0] msr_i,
  output logic [31:0] srr0_o,
  output logic [31:0] srr1_o,
  output logic [31:0] msr_o,
  output logic [31:0] dsisr_o,
  output logic [31:0] dar_o,
  output logic [31:0] bar_o,
  output logic [31:0] vector_o,
  output logic        srr_unspec_o
);
  exc_cause_e      cause;
  logic [NCAUSE-1:0] req;
  logic [XLEN-1:0] srr0_nx, srr1_nx, msr_nx, dsisr_nx, vector_nx;
  logic            any_nx, wr_dsi, wr_bar;
  logic            armed_q, boot_devp, fire;

  assign req = {pbrk_i, lbrk_i, ibrk_i, devp_i, dtlb_err_i};

  exc_cause_arb u_arb (
    .req_i   (req),
    .cause_o (cause)
  );

  exc_next_calc #(
    .HI_BASE (HI_BASE),
    .LO_BASE (LO_BASE)
  ) u_calc (
    .cause_i   (cause),
    .miss_i    (tlb_miss_i),
    .prot_i    (prot_viol_i),
    .store_i   (is_store_i),
    .cur_ea_i  (cur_ea_i),
    .next_ea_i (next_ea_i),
    .msr_i     (msr_i),
    .srr0_o    (srr0_nx),
    .srr1_o    (srr1_nx),
    .msr_o     (msr_nx),
    .dsisr_o   (dsisr_nx),
    .vector_o  (vector_nx),
    .any_o     (any_nx),
    .wr_dsi_o  (wr_dsi),
    .wr_bar_o  (wr_bar)
  );

  // high only until the first edge after reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b1;
    else         armed_q <= 1'b0;
  end

  assign fire      = take_i & any_nx;
  assign boot_devp = armed_q & (cause == CAUSE_DEVP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      srr0_o       <= '0;
      srr1_o       <= '0;
      msr_o        <= '0;
      dsisr_o      <= '0;
      dar_o        <= '0;
      bar_o        <= '0;
      vector_o     <= '0;
      srr_unspec_o <= 1'b0;
    end else if (fire) begin
      msr_o        <= msr_nx;
      vector_o     <= vector_nx;
      srr_unspec_o <= boot_devp;
      if (!boot_devp) begin
        srr0_o <= srr0_nx;
        srr1_o <= srr1_nx;
      end
      if (wr_dsi) begin
        dsisr_o <= dsisr_nx;
        dar_o   <= data_ea_i;
      end
      if (wr_bar) bar_o <= data_ea_i;
    end
  end
endmodule

// File: rtl/exc_capture_chk.sv
module exc_capture_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        take_i,
  input logic        dtlb_err_i,
  input logic        tlb_miss_i,
  input logic        prot_viol_i,
  input logic        is_store_i,
  input logic        ibrk_i,
  input logic        lbrk_i,
  input logic        devp_i,
  input logic [31:0] data_ea_i,
  input logic [31:0] msr_i,
  input logic [31:0] srr0_o,
  input logic [31:0] srr1_o,
  input logic [31:0] msr_o,
  input logic [31:0] dsisr_o,
  input logic [31:0] dar_o,
  input logic [31:0] bar_o,
  input logic [31:0] vector_o
);
  p_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !take_i |=> $stable(srr0_o) && $stable(srr1_o) && $stable(msr_o) && $stable(dsisr_o)
               && $stable(dar_o) && $stable(bar_o) && $stable(vector_o));

  p_prio_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i && devp_i && !dtlb_err_i |=> vector_o[15:0] == 16'h1F00);

  p_dsisr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i && dtlb_err_i |=> dsisr_o == {1'b0, $past(tlb_miss_i), 2'b00, $past(prot_viol_i),
                                         1'b0, $past(is_store_i), 25'd0});

  p_dar_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i && dtlb_err_i |=> dar_o == $past(data_ea_i) && $stable(bar_o));

  p_vec_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i && dtlb_err_i |=> vector_o[15:0] == 16'h1400);

  p_srr1_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i && dtlb_err_i |=> srr1_o == ($past(msr_i) & 32'h0000_FFFF));

  p_msr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i && dtlb_err_i |=> msr_o[12] == $past(msr_i[12]) && msr_o[0] == $past(msr_i[16])
                            && msr_o[6] == $past(msr_i[6]) && $countones(msr_o) <= 3);

  p_bar_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i && lbrk_i && !dtlb_err_i && !devp_i && !ibrk_i |=>
      bar_o == $past(data_ea_i) && $stable(dsisr_o) && $stable(dar_o));
endmodule

bind exc_state_capture exc_capture_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .take_i      (take_i),
  .dtlb_err_i  (dtlb_err_i),
  .tlb_miss_i  (tlb_miss_i),
  .prot_viol_i (prot_viol_i),
  .is_store_i  (is_store_i),
  .ibrk_i      (ibrk_i),
  .lbrk_i      (lbrk_i),
  .devp_i      (devp_i),
  .data_ea_i   (data_ea_i),
  .msr_i       (msr_i),
  .srr0_o      (srr0_o),
  .srr1_o      (srr1_o),
  .msr_o       (msr_o),
  .dsisr_o     (dsisr_o),
  .dar_o       (dar_o),
  .bar_o       (bar_o),
  .vector_o    (vector_o)
);

// File: tb/tb_exc_state_capture.sv
`timescale 1ns/1ps
module tb_exc_state_capture;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic take, dtlb, miss, prot, store, ibrk, lbrk, pbrk, devp;
  logic [31:0] cur_ea, next_ea, data_ea, msr;
  logic [31:0] srr0, srr1, msr_q, dsisr, dar, bar, vec;
  logic unspec;

  logic [31:0] e_srr0, e_srr1, e_msr, e_dsisr, e_dar, e_bar, e_vec;
  logic e_unspec;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  exc_state_capture dut (
    .clk_i(clk), .rst_ni(rst_ni), .take_i(take), .dtlb_err_i(dtlb), .tlb_miss_i(miss),
    .prot_viol_i(prot), .is_store_i(store), .ibrk_i(ibrk), .lbrk_i(lbrk), .pbrk_i(pbrk),
    .devp_i(devp), .cur_ea_i(cur_ea), .next_ea_i(next_ea), .data_ea_i(data_ea), .msr_i(msr),
    .srr0_o(srr0), .srr1_o(srr1), .msr_o(msr_q), .dsisr_o(dsisr), .dar_o(dar), .bar_o(bar),
    .vector_o(vec), .srr_unspec_o(unspec)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // 0 none, 1 dtlb, 2 devp, 3 ibrk, 4 lbrk, 5 pbrk
  function automatic int pick();
    if (dtlb) return 1;
    if (devp) return 2;
    if (ibrk) return 3;
    if (lbrk) return 4;
    if (pbrk) return 5;
    return 0;
  endfunction

  function automatic string tag_of(int c);
    case (c)
      1: return "R2/R3/R4/R5";
      2: return "R2/R6/R10";
      3: return "R2/R6";
      4: return "R6/R9";
      5: return "R5/R6";
      default: return "R1";
    endcase
  endfunction

  task automatic model(input bit first);
    int c = pick();
    logic [31:0] base;
    if (!take || c == 0) return;
    base = msr[6] ? 32'hFFF0_0000 : 32'h0;
    e_msr = (msr & 32'h0000_1040) | {31'd0, msr[16]};
    e_unspec = 1'b0;
    case (c)
      1: begin
        e_srr0 = cur_ea; e_srr1 = msr & 32'hFFFF; e_dar = data_ea;
        e_dsisr = ({31'd0, miss} << 30) | ({31'd0, prot} << 27) | ({31'd0, store} << 25);
        e_vec = base | 32'h1400;
      end
      2: begin
        if (first) e_unspec = 1'b1;
        else begin e_srr0 = next_ea; e_srr1 = msr & 32'hFFFF; end
        e_vec = base | 32'h1F00;
      end
      3: begin e_srr0 = cur_ea; e_srr1 = msr & 32'hFFFF; e_vec = base | 32'h1D00; end
      4: begin e_srr0 = next_ea; e_srr1 = msr & 32'hFFFF; e_bar = data_ea; e_vec = base | 32'h1C00; end
      default: begin e_srr0 = next_ea; e_srr1 = msr & 32'hFFFF; e_vec = base | 32'h1E00; end
    endcase
  endtask

  task automatic check_all(input string t);
    chk({t, " srr0"}, srr0, e_srr0);
    chk({t, " srr1 R7"}, srr1, e_srr1);
    chk({t, " msr R8"}, msr_q, e_msr);
    chk({t, " dsisr"}, dsisr, e_dsisr);
    chk({t, " dar"}, dar, e_dar);
    chk({t, " bar"}, bar, e_bar);
    chk({t, " vector"}, vec, e_vec);
    chk({t, " unspec"}, {31'd0, unspec}, {31'd0, e_unspec});
  endtask

  task automatic set_rand(input int pct);
    dtlb = ($urandom % 100) < pct / 2;
    devp = ($urandom % 100) < pct / 2;
    ibrk = ($urandom % 100) < pct;
    lbrk = ($urandom % 100) < pct;
    pbrk = ($urandom % 100) < pct;
    miss = $urandom; prot = $urandom; store = $urandom;
    cur_ea = $urandom; next_ea = $urandom; data_ea = $urandom; msr = $urandom;
  endtask

  // drive at negedge, strobe for one edge, check at following negedge
  task automatic step(input logic tk, input string t);
    take = tk;
    model(1'b0);
    @(posedge clk);
    @(negedge clk);
    take = 1'b0;
    check_all(t);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    {e_srr0, e_srr1, e_msr, e_dsisr, e_dar, e_bar, e_vec} = '0;
    e_unspec = 1'b0;
    // R10: development port request held through reset
    take = 1'b1; devp = 1'b1; dtlb = 0; ibrk = 0; lbrk = 0; pbrk = 0;
    miss = 0; prot = 0; store = 0;
    cur_ea = 32'h1111_0000; next_ea = 32'h2222_0004; data_ea = 32'h3333_0008;
    msr = 32'h0001_0040;
    repeat (3) @(negedge clk);
    check_all("R11 reset");
    rst_ni = 1'b1;
    model(1'b1);
    @(posedge clk);
    @(negedge clk);
    take = 1'b0;
    check_all("R10 boot devp");
    // R10: later devp takes save normally and clear the flag
    step(1'b1, "R10 devp later");

    // R1: causes present but no strobe; strobe with no cause
    dtlb = 1; ibrk = 1; lbrk = 1; msr = 32'hFFFF_FFFF; data_ea = 32'hDEAD_BEEF;
    step(1'b0, "R1 no strobe");
    {dtlb, devp, ibrk, lbrk, pbrk} = '0;
    step(1'b1, "R1 no cause");

    // R2: all causes together, translation error wins
    {dtlb, devp, ibrk, lbrk, pbrk} = '1;
    miss = 1; prot = 1; store = 1; msr = 32'h0001_1040;
    step(1'b1, "R2 all causes R3");
    dtlb = 0;
    step(1'b1, "R2 debug all devp");
    devp = 0;
    step(1'b1, "R2 ibrk over lbrk");
    ibrk = 0; data_ea = 32'hCAFE_F00D;
    step(1'b1, "R9 lbrk BAR");
    lbrk = 0; msr = 32'h0;
    step(1'b1, "R5 pbrk low base");

    for (int i = 0; i < 600; i++) begin
      set_rand(35);
      step(($urandom % 4) != 0, tag_of(pick()));
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule